// File: doc/BRIEF.md
# Multi-Controller Joypad Forwarder

This block sits between a host processor and a handheld console's joypad matrix. The host writes the state of up to four 8-bit controllers into the block. The handheld scans the matrix by pulling one or both of its two select lines low, and reads back a 4-bit active-low nibble. That nibble holds either the direction keys or the action keys of the controller that is currently active.

A control register written by the host does three things:
- it holds the handheld in reset or lets it run;
- it sets how many controllers take part in play;
- it picks one of four clock-divide settings, which the block passes out unchanged.

When more than one controller is enabled, the block moves to the next controller whenever the handheld pulls the button-select line low and then releases both select lines. The index wraps around at the configured count.

Host writes use a valid/ready channel. The block accepts a write in every cycle, so ready is always high and there is never back-pressure. A write takes effect when valid is high at a rising clock edge.

Top module: `joy_fwd_top`

## Requirements
- R1: After reset, every controller register reads as 8'hFF (nothing pressed), run is low, the count code is 0, the divider select is 0 and the active index is 0.
- R2: A write with wr_valid high loads controller register n when wr_sel equals n (0 to 3) and loads the control register when wr_sel equals 4. Writes to wr_sel 5 to 7 change no state. wr_ready is always 1.
- R3: Control bit 7 drives hh_run (1 means run, 0 means hold in reset). Bits 1:0 drive div_sel. Bits 5:4 drive pad_count.
- R4: Controller bits from 7 down to 0 are Start, Select, B, A, Down, Up, Left, Right, all active-low. When dpad_sel_n (bit-4 select) alone is low, joy_nib equals bits 3:0 of the active controller. When btn_sel_n (bit-5 select) alone is low, joy_nib equals bits 7:4.
- R5: When both select lines are low, joy_nib is the bitwise AND of the two nibbles. When both are high, joy_nib is 4'hF.
- R6: While running with a count code other than 0, the active index advances by one at the first rising edge where both select lines are high, provided btn_sel_n was sampled low at some earlier edge since the last advance.
- R7: The index wraps modulo the player count. Code 1 means two players, code 3 means four players, and code 2 behaves like code 1. An index above the current limit returns to 0 at the next edge.
- R8: While hh_run is low, the active index is held at 0 and any partial select sequence is discarded.
- R9: With count code 0 the index stays at 0 regardless of select activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write valid |
| wr_ready | output | 1 | Host write ready, always 1 |
| wr_sel | input | 3 | Register select: 0-3 controllers, 4 control |
| wr_data | input | 8 | Write data |
| dpad_sel_n | input | 1 | Handheld direction-key select, active low |
| btn_sel_n | input | 1 | Handheld action-key select, active low |
| joy_nib | output | 4 | Returned key nibble, active low |
| pad_index | output | 2 | Index of active controller |
| hh_run | output | 1 | 1 lets the handheld run, 0 holds it in reset |
| pad_count | output | 2 | Controller count code |
| div_sel | output | 2 | Clock divider selection |

## Verification
The bench targets the advance rule. A design that advanced when btn_sel_n fell, or on every both-high cycle without an earlier btn_sel_n low, would step the index too early or too often during a plain direction-key scan.

Wrap behaviour is driven with each count code, including code 2. A design that decoded the count literally would reach index 2 or 3 with two players. Shrinking the count while the index is high exposes a design that never clamps an out-of-range index.

Reset-hold and writes to unused selects are checked at the nibble and index outputs. A design that let the index run while held in reset, or that aliased selects 5 to 7 onto a register, shows a wrong nibble.

// File: rtl/joy_fwd_pkg.sv
package joy_fwd_pkg;
  localparam int NUM_PADS = 4;
  localparam int PAD_W    = 8;
  localparam int NIB_W    = PAD_W / 2;
  localparam int IDX_W    = $clog2(NUM_PADS);
  localparam int SEL_W    = 3;

  localparam int CTL_RUN_BIT = 7;
  localparam int CTL_CNT_LO  = 4;
  localparam int CTL_DIV_LO  = 0;

  // highest usable index for a count code: 0->0, 1->1, 2->1, 3->3
  function automatic logic [IDX_W-1:0] idx_limit(input logic [1:0] code);
    case (code)
      2'd0:    idx_limit = '0;
      2'd3:    idx_limit = IDX_W'(NUM_PADS - 1);
      default: idx_limit = IDX_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/joy_regfile.sv
module joy_regfile
  import joy_fwd_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [PAD_W-1:0]               wr_data,
  output logic [NUM_PADS-1:0][PAD_W-1:0] pads,
  output logic                           run,
  output logic [1:0]                     cnt_code,
  output logic [1:0]                     div_code
);
  logic [PAD_W-1:0] ctl_q;

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pads[g] <= '1;
      else if (wr_en && wr_sel == SEL_W'(g))
        pads[g] <= wr_data;
    end

    AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(pads[g])); // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (wr_en && wr_sel == SEL_W'(NUM_PADS))
      ctl_q <= wr_data;
  end

  assign run      = ctl_q[CTL_RUN_BIT];
  assign cnt_code = ctl_q[CTL_CNT_LO +: 2];
  assign div_code = ctl_q[CTL_DIV_LO +: 2];

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > SEL_W'(NUM_PADS)) |=> $stable(ctl_q)); // R2
endmodule

// File: rtl/joy_rotator.sv
module joy_rotator
  import joy_fwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       cnt_code,
  input  logic             dpad_sel_n,
  input  logic             btn_sel_n,
  output logic [IDX_W-1:0] idx
);
  logic             armed_q;
  logic [IDX_W-1:0] limit;
  logic             advance;

  assign limit   = idx_limit(cnt_code);
  assign advance = armed_q && dpad_sel_n && btn_sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idx     <= '0;
    end else if (!run) begin
      armed_q <= 1'b0;
      idx     <= '0;
    end else begin
      if (!btn_sel_n)
        armed_q <= 1'b1;
      else if (advance)
        armed_q <= 1'b0;

      if (idx > limit)
        idx <= '0;
      else if (advance)
        idx <= (idx == limit) ? '0 : idx + 1'b1;
    end
  end

  AST_IDX_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> idx == '0); // R8
  AST_SINGLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_code == 2'd0) |=> idx == '0); // R9
  AST_NO_STEP_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (!dpad_sel_n || !btn_sel_n) && idx <= limit) |=> $stable(idx)); // R6
  AST_TWO_PLAYER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_code == 2'd1 || cnt_code == 2'd2) |=> idx <= IDX_W'(1)); // R7
endmodule

// File: rtl/joy_nib_mux.sv
module joy_nib_mux
  import joy_fwd_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PADS-1:0][PAD_W-1:0] pads,
  input  logic [IDX_W-1:0]               idx,
  input  logic                           dpad_sel_n,
  input  logic                           btn_sel_n,
  output logic [NIB_W-1:0]               nib
);
  logic [PAD_W-1:0] cur;
  logic [NIB_W-1:0] lo_part, hi_part;

  assign cur     = pads[idx];
  assign lo_part = dpad_sel_n ? '1 : cur[NIB_W-1:0];
  assign hi_part = btn_sel_n  ? '1 : cur[PAD_W-1:NIB_W];
  assign nib     = lo_part & hi_part;

  AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dpad_sel_n && btn_sel_n) |-> nib == '1); // R5
  AST_DPAD_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpad_sel_n && btn_sel_n) |-> nib == pads[idx][NIB_W-1:0]); // R4
endmodule

// File: rtl/joy_fwd_top.sv
module joy_fwd_top
  import joy_fwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       dpad_sel_n,
  input  logic       btn_sel_n,
  output logic [3:0] joy_nib,
  output logic [1:0] pad_index,
  output logic       hh_run,
  output logic [1:0] pad_count,
  output logic [1:0] div_sel
);
  logic [NUM_PADS-1:0][PAD_W-1:0] pads;
  logic                           run;
  logic [1:0]                     cnt_code;
  logic [1:0]                     div_code;
  logic [IDX_W-1:0]               idx;

  assign wr_ready = 1'b1;

  joy_regfile u_regs (
    .clk, .rst_n,
    .wr_en   (wr_valid && wr_ready),
    .wr_sel, .wr_data,
    .pads, .run, .cnt_code, .div_code
  );

  joy_rotator u_rot (
    .clk, .rst_n, .run, .cnt_code,
    .dpad_sel_n, .btn_sel_n, .idx
  );

  joy_nib_mux u_mux (
    .clk, .rst_n, .pads, .idx,
    .dpad_sel_n, .btn_sel_n, .nib (joy_nib)
  );

  assign pad_index = idx;
  assign hh_run    = run;
  assign pad_count = cnt_code;
  assign div_sel   = div_code;
endmodule

// File: tb/test_joy_fwd_top.sv
module test_joy_fwd_top;
  logic       clk = 0, rst_n = 0;
  logic       wr_valid = 0, wr_ready;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic       dpad_sel_n = 1, btn_sel_n = 1;
  logic [3:0] joy_nib;
  logic [1:0] pad_index, pad_count, div_sel;
  logic       hh_run;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  joy_fwd_top i_joy_fwd_top (.*);

  // bench-side model of the requirements
  logic [7:0] m_pad [4];
  logic [7:0] m_ctl;
  logic [1:0] m_idx;
  logic       m_arm;

  function automatic logic [1:0] lim(input logic [1:0] c);
    return (c == 2'd0) ? 2'd0 : (c == 2'd3) ? 2'd3 : 2'd1;
  endfunction

  function automatic logic [3:0] exp_nib(input logic [7:0] p, input logic d, input logic b);
    logic [3:0] r = 4'hF;
    if (!d) r = r & p[3:0];
    if (!b) r = r & p[7:4];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_pad[i] <= 8'hFF;
      m_ctl <= 0; m_idx <= 0; m_arm <= 0;
    end else begin
      if (wr_valid && wr_sel < 4) m_pad[wr_sel] <= wr_data;
      if (wr_valid && wr_sel == 4) m_ctl <= wr_data;
      if (!m_ctl[7]) begin
        m_idx <= 0; m_arm <= 0;
      end else begin
        if (!btn_sel_n) m_arm <= 1;
        else if (m_arm && dpad_sel_n) m_arm <= 0;
        if (m_idx > lim(m_ctl[5:4])) m_idx <= 0;
        else if (m_arm && dpad_sel_n && btn_sel_n)
          m_idx <= (m_idx == lim(m_ctl[5:4])) ? 2'd0 : m_idx + 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check just before the next rising edge
  task automatic cyc(input logic wv, input logic [2:0] s, input logic [7:0] d,
                     input logic dp, input logic bt, input string tag);
    @(negedge clk);
    wr_valid = wv; wr_sel = s; wr_data = d; dpad_sel_n = dp; btn_sel_n = bt;
    #2;
    chk(tag, "nibble", {4'h0, joy_nib}, {4'h0, exp_nib(m_pad[m_idx], dp, bt)});
    chk(tag, "index", {6'h0, pad_index}, {6'h0, m_idx});
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d, input string tag);
    cyc(1, s, d, 1, 1, tag);
  endtask

  task automatic step(string tag);   // btn low, then both high
    cyc(0, 0, 0, 1, 0, tag);
    cyc(0, 0, 0, 1, 1, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk("R1", "run", {7'h0, hh_run}, 8'h0);
    chk("R1", "count", {6'h0, pad_count}, 8'h0);
    chk("R1", "div", {6'h0, div_sel}, 8'h0);
    chk("R1", "index", {6'h0, pad_index}, 8'h0);
    chk("R2", "ready", {7'h0, wr_ready}, 8'h1);
    cyc(0, 0, 0, 0, 0, "R1");   // FF pads give F when both lines low

    // load pads, control: run, count code 0, divider 2
    wr(0, 8'h5A, "R2"); wr(1, 8'hC3, "R2"); wr(2, 8'h96, "R2"); wr(3, 8'h0F, "R2");
    wr(4, 8'h82, "R3");
    cyc(0, 0, 0, 1, 1, "R3");
    chk("R3", "run", {7'h0, hh_run}, 8'h1);
    chk("R3", "div", {6'h0, div_sel}, 8'h2);
    chk("R3", "count", {6'h0, pad_count}, 8'h0);
    cyc(0, 0, 0, 0, 1, "R4");   // direction nibble
    cyc(0, 0, 0, 1, 0, "R4");   // action nibble
    cyc(0, 0, 0, 0, 0, "R5");   // AND of both
    cyc(0, 0, 0, 1, 1, "R5");
    // unused selects must not change anything
    wr(5, 8'h00, "R2"); wr(7, 8'h11, "R2");
    cyc(0, 0, 0, 0, 0, "R2");
    chk("R2", "ctl after unused write", {hh_run, 1'b0, pad_count, 2'b0, div_sel}, 8'h82);
    // single player: index stays 0
    step("R9"); step("R9");
    // two players: no advance on direction-only scan
    wr(4, 8'h91, "R3");
    cyc(0, 0, 0, 0, 1, "R6"); cyc(0, 0, 0, 1, 1, "R6");
    step("R6"); step("R7"); step("R7");
    // code 2 behaves as two
    wr(4, 8'hA0, "R7");
    step("R7"); step("R7"); step("R7");
    // four players
    wr(4, 8'hB3, "R7");
    for (int i = 0; i < 5; i++) step("R7");
    // arm then hold btn low several cycles, dpad low too
    cyc(0, 0, 0, 1, 0, "R6"); cyc(0, 0, 0, 0, 0, "R6"); cyc(0, 0, 0, 0, 1, "R6");
    cyc(0, 0, 0, 1, 1, "R6");
    // go to index 3 then shrink count: clamp to 0
    while (m_idx != 3) step("R7");
    wr(4, 8'h90, "R7"); cyc(0, 0, 0, 1, 1, "R7"); cyc(0, 0, 0, 1, 1, "R7");
    // hold in reset: index 0, armed state dropped
    wr(4, 8'hB0, "R8"); step("R8");
    cyc(0, 0, 0, 1, 0, "R8");
    wr(4, 8'h30, "R8"); cyc(0, 0, 0, 1, 1, "R8");
    wr(4, 8'hB0, "R8"); cyc(0, 0, 0, 1, 1, "R8"); cyc(0, 0, 0, 1, 1, "R8");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic wv; logic [2:0] s; logic [7:0] d;
      wv = ($urandom % 8) == 0;
      s  = $urandom % 8;
      d  = $urandom;
      if (s == 4) d[7] = ($urandom % 6) != 0;
      cyc(wv, s, d, $urandom % 2, $urandom % 2, "R6");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule